// File: doc/BRIEF.md
# Blanking-Interval Stereo Audio Recovery

This block sits on the receive side of a serial video link, in the recovered pixel-clock domain. Each pixel clock it is handed the 27-bit parallel word that the deserializer rebuilt. While the word is a video pixel, the block ignores it. While the word is a blanking word, a few control bits carry a tunnelled serial audio stream: data, word select and, in one mode, a slow bit clock and a chip select. The block rebuilds the serial audio bit stream from those bits, frames 16-bit left and right samples, and stores each complete stereo pair in a small show-ahead FIFO for a downstream DAC or decoder.

There are two bit-clock sources. With the pixel source, every blanking pixel clock is a bit slot, and a tunnelled active-low select pauses the flow. With the tunnelled source, a control bit toggles as a slow bit clock, and its rising edges are the bit slots. Holding that bit low pauses the flow. The link has no return channel, so the FIFO fill level is brought out. Clock logic elsewhere uses it to lock the consumer's rate to the pixel rate.

Top module: `blank_audio_extract`

## Requirements
- R1: After reset the FIFO is empty, `fifo_level` is 0 and `overrun` is 0.
- R2: A word with bit 2 high is an active-video word and has no effect at all. Its data, word-select and clock bits are not sampled, and it counts as neither a high nor a low level of the tunnelled bit clock.
- R3: With `clk_src` = 0 (pixel source), each blanking word with bit 6 low carries one audio bit. A blanking word with bit 6 high carries none. Bit 5 is ignored.
- R4: With `clk_src` = 1 (tunnelled source), a blanking word carries one audio bit when its bit 5 is high and bit 5 of the previous blanking word was low. That history reads as low after reset. Bit 6 is ignored.
- R5: In a word that carries an audio bit, bit 3 is the serial data and bit 4 is the word select.
- R6: The audio bit that first shows a new word-select value is the last bit of the previous word. The following bits fill the new word MSB first. A word is complete at its 16th bit, and further bits before the next word-select change are discarded. Bits received before the first word-select change are discarded.
- R7: Word select 0 marks a left word and 1 a right word. When a right word completes after a complete left word of the same frame, the entry {left, right} (left in bits 31:16) is written to the FIFO on the clock edge that samples that completing bit.
- R8: A word-select change that arrives before 16 bits were collected discards the partial word. A discarded left word produces no entry for its frame, and neither does a discarded right word.
- R9: Active-video words inside a word freeze its collection. The word continues with the next audio bit, with no bit lost or added.
- R10: A pair that completes while the FIFO holds `DEPTH` entries is dropped, and `overrun` goes to 1 and stays at 1 until reset.
- R11: `sample_pair` shows the oldest entry, and `pop` removes it at the clock edge. A `pop` on an empty FIFO is ignored. `fifo_level` gives the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | recovered pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| clk_src | input | 1 | bit clock source: 0 pixel clock with select, 1 tunnelled clock bit |
| link_word | input | 27 | deserialized parallel word |
| pop | input | 1 | remove the oldest stereo entry |
| sample_pair | output | 32 | oldest entry, left in 31:16, right in 15:0 |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_level | output | 4 | number of entries held |
| overrun | output | 1 | sticky: a pair was dropped on a full FIFO |

## Verification
A bit counter or shift register that slips by one position shows at the ports as a stereo entry whose halves are shifted by one bit. It can also show as a missing entry, visible at `fifo_level` on the clock edge right after the completing bit. A stale word-select history or left-valid flag shows as an extra entry, or a lost one, after a truncated word. A wrong tunnelled-clock history shows as an extra or missing bit inside the first word after a pause. The bench frames known samples with random gaps, active words and paused slots between bits, so any such fault corrupts the next entry that is read out.

// File: rtl/bae_pkg.sv
package bae_pkg;
  localparam int LINK_W   = 27;
  localparam int POS_ENAB = 2;
  localparam int POS_SD   = 3;
  localparam int POS_WS   = 4;
  localparam int POS_SCK  = 5;
  localparam int POS_CSN  = 6;

  typedef enum logic {
    SRC_PIXEL  = 1'b0,
    SRC_TUNNEL = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic sd;
    logic ws;
  } aud_bit_t;
endpackage

// File: rtl/bae_strobe_gen.sv
module bae_strobe_gen
  import bae_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tunnel,
  input  logic [LINK_W-1:0] link_word,
  output logic              bit_strobe,
  output aud_bit_t          bit_val
);
  logic blank;
  logic sck_now;
  logic sck_hist_q, sck_hist_d;

  assign blank   = ~link_word[POS_ENAB];
  assign sck_now = link_word[POS_SCK];
  assign bit_val = '{sd: link_word[POS_SD], ws: link_word[POS_WS]};

  // clock history advances only on blanking words
  always_comb begin
    sck_hist_d = sck_hist_q;
    if (blank) sck_hist_d = sck_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sck_hist_q <= 1'b0;
    else if (blank) sck_hist_q <= sck_hist_d;
  end

  always_comb begin
    bit_strobe = 1'b0;
    if (blank) begin
      if (src_tunnel) bit_strobe = sck_now & ~sck_hist_q;
      else            bit_strobe = ~link_word[POS_CSN];
    end
  end

  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_word[POS_ENAB] |=> $stable(sck_hist_q));
endmodule

// File: rtl/bae_word_asm.sv
module bae_word_asm
  import bae_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_strobe,
  input  aud_bit_t              bit_val,
  output logic                  pair_push,
  output logic [2*WORD_W-1:0]   pair_data
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              have_ws_q, have_ws_d;
  logic              ws_last_q, ws_last_d;
  logic              armed_q,   armed_d;
  logic              chan_q,    chan_d;
  logic [CW-1:0]     cnt_q,     cnt_d;
  logic [WORD_W-1:0] sh_q,      sh_d;
  logic [WORD_W-1:0] left_q,    left_d;
  logic              lok_q,     lok_d;
  logic              word_done;

  always_comb begin
    have_ws_d = have_ws_q;
    ws_last_d = ws_last_q;
    armed_d   = armed_q;
    chan_d    = chan_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    left_d    = left_q;
    lok_d     = lok_q;
    word_done = 1'b0;
    pair_push = 1'b0;
    pair_data = {left_q, sh_q};
    if (bit_strobe) begin
      have_ws_d = 1'b1;
      ws_last_d = bit_val.ws;
      if (armed_q && (cnt_q < CW'(WORD_W))) begin
        sh_d  = {sh_q[WORD_W-2:0], bit_val.sd};
        cnt_d = cnt_q + 1'b1;
        word_done = (cnt_q == CW'(WORD_W - 1));
      end
      if (word_done) begin
        if (!chan_q) begin
          left_d = sh_d;
          lok_d  = 1'b1;
        end else if (lok_q) begin
          pair_push = 1'b1;
          pair_data = {left_q, sh_d};
          lok_d     = 1'b0;
        end
      end
      if (have_ws_q && (bit_val.ws != ws_last_q)) begin
        armed_d = 1'b1;
        chan_d  = bit_val.ws;
        cnt_d   = '0;
        if (!bit_val.ws) lok_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ws_q <= 1'b0;
      ws_last_q <= 1'b0;
      armed_q   <= 1'b0;
      chan_q    <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      left_q    <= '0;
      lok_q     <= 1'b0;
    end else if (bit_strobe) begin
      have_ws_q <= have_ws_d;
      ws_last_q <= ws_last_d;
      armed_q   <= armed_d;
      chan_q    <= chan_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      left_q    <= left_d;
      lok_q     <= lok_d;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WORD_W));
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> $stable(cnt_q) && $stable(sh_q));
  assert_pair_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_push |-> chan_q && lok_q && armed_q);
endmodule

// File: rtl/bae_fifo.sv
module bae_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic [$clog2(DEPTH):0] level,
  output logic          overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic          ovr_q, ovr_d;
  logic          full, wr_en, rd_en;

  assign level = wp_q - rp_q;
  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign wr_en = push & ~full;
  assign rd_en = pop & ~empty;
  assign rdata = mem[rp_q[AW-1:0]];
  assign overrun = ovr_q;

  always_comb begin
    wp_d  = wp_q + LW'(wr_en);
    rp_d  = rp_q + LW'(rd_en);
    ovr_d = ovr_q | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q[AW-1:0]] <= wdata;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  assert_drop_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> level == LW'(DEPTH) && overrun);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push |=> empty);
endmodule

// File: rtl/blank_audio_extract.sv
module blank_audio_extract
  import bae_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk_pix,
  input  logic              rst_n,
  input  logic              clk_src,
  input  logic [LINK_W-1:0] link_word,
  input  logic              pop,
  output logic [PAIR_W-1:0] sample_pair,
  output logic              fifo_empty,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              overrun
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              strobe;
  aud_bit_t          abit;
  logic              push;
  logic [PAIR_W-1:0] pair;

  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  bae_strobe_gen u_strobe (
    .clk        (clk_pix),
    .rst_n      (core_rst_n),
    .src_tunnel (clk_src == SRC_TUNNEL),
    .link_word  (link_word),
    .bit_strobe (strobe),
    .bit_val    (abit)
  );

  bae_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk        (clk_pix),
    .rst_n      (core_rst_n),
    .bit_strobe (strobe),
    .bit_val    (abit),
    .pair_push  (push),
    .pair_data  (pair)
  );

  bae_fifo #(.DW(PAIR_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk_pix),
    .rst_n   (core_rst_n),
    .push    (push),
    .wdata   (pair),
    .pop     (pop),
    .rdata   (sample_pair),
    .empty   (fifo_empty),
    .level   (fifo_level),
    .overrun (overrun)
  );
endmodule

// File: tb/blank_audio_extract_tb_top.sv
`timescale 1ns/1ps
module blank_audio_extract_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_src;
  logic [26:0] link_word;
  logic        pop;
  logic [31:0] sample_pair;
  logic        fifo_empty;
  logic [3:0]  fifo_level;
  logic        overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit noisy  = 0;
  logic [31:0] expq [$];

  always #10 clk = ~clk;

  blank_audio_extract dut_i (
    .clk_pix(clk), .rst_n(rst_n), .clk_src(clk_src), .link_word(link_word),
    .pop(pop), .sample_pair(sample_pair), .fifo_empty(fifo_empty),
    .fifo_level(fifo_level), .overrun(overrun)
  );

  function automatic logic rb();
    return 1'($urandom & 1);
  endfunction

  function automatic logic [26:0] mkw(logic en, logic sd, logic ws, logic sck, logic csn);
    logic [26:0] w;
    w = 27'($urandom);
    w[2] = en; w[3] = sd; w[4] = ws; w[5] = sck; w[6] = csn;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [26:0] w);
    link_word = w;
    @(posedge clk);
    #2;
  endtask

  task automatic active_gap();
    if (noisy) repeat ($urandom % 3) step(mkw(1'b1, rb(), rb(), rb(), rb()));
  endtask

  // one audio bit, framed for the current clock source
  task automatic send_bit(logic sd, logic ws);
    active_gap();
    if (clk_src == 1'b0) begin
      if (noisy && ($urandom % 3 == 0)) step(mkw(1'b0, rb(), rb(), rb(), 1'b1));
      step(mkw(1'b0, sd, ws, rb(), 1'b0));
    end else begin
      step(mkw(1'b0, rb(), rb(), 1'b0, rb()));
      if (noisy && ($urandom % 2 == 0)) step(mkw(1'b0, rb(), rb(), 1'b0, rb()));
      active_gap();
      step(mkw(1'b0, sd, ws, 1'b1, rb()));
      if (noisy) repeat ($urandom % 3) step(mkw(1'b0, rb(), rb(), 1'b1, rb()));
    end
  endtask

  task automatic preamble();
    send_bit(rb(), 1'b1);
    send_bit(rb(), 1'b0);
  endtask

  task automatic send_frame(logic [15:0] l, logic [15:0] r, int sl, int sr);
    for (int k = 0; k < sl; k++)
      send_bit((k < 16) ? l[15-k] : rb(), (k == sl - 1));
    for (int k = 0; k < sr; k++)
      send_bit((k < 16) ? r[15-k] : rb(), !(k == sr - 1));
    if (sl >= 16 && sr >= 16 && expq.size() < DEPTH) expq.push_back({l, r});
  endtask

  task automatic drain(string tag);
    chk({tag, " level"}, 32'(fifo_level), 32'(expq.size()));
    while (expq.size() > 0) begin
      chk({tag, " empty"}, 32'(fifo_empty), 32'd0);
      chk({tag, " data"}, sample_pair, expq.pop_front());
      pop = 1'b1;
      step(mkw(1'b1, rb(), rb(), rb(), rb()));
      pop = 1'b0;
    end
    chk({tag, " drained"}, 32'(fifo_empty), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; clk_src = 1'b0; pop = 1'b0;
    link_word = 27'h4;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) step(27'h4);

    // R1 reset state
    chk("R1 empty", 32'(fifo_empty), 32'd1);
    chk("R1 level", 32'(fifo_level), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);

    // R5/R6/R7 directed pixel-source frame, entry visible right after last bit
    preamble();
    send_frame(16'hA5C3, 16'h1234, 16, 16);
    chk("R7 level after right word", 32'(fifo_level), 32'd1);
    drain("R5 R6 R7 directed");

    // R2 active words alone do nothing
    repeat (12) step(mkw(1'b1, rb(), rb(), rb(), rb()));
    chk("R2 active only level", 32'(fifo_level), 32'd0);

    // R3 R9 pixel source with select pauses and active gaps
    noisy = 1;
    send_frame(16'h8001, 16'h7FFE, 16, 16);
    send_frame(16'hF0F0, 16'h0F0F, 16, 16);
    drain("R3 R9 gated pixel source");

    // R6 long slots, trailing bits dropped
    noisy = 0;
    send_frame(16'hBEEF, 16'hCAFE, 20, 18);
    drain("R6 long slots");

    // R8 partial words discard their frame
    send_frame(16'h1111, 16'h2222, 9, 16);
    chk("R8 short left no entry", 32'(fifo_level), 32'd0);
    send_frame(16'h3333, 16'h4444, 16, 12);
    chk("R8 short right no entry", 32'(fifo_level), 32'd0);
    send_frame(16'h5A5A, 16'hA5A5, 16, 16);
    drain("R8 resync");

    // R4 tunnelled clock
    clk_src = 1'b1;
    send_frame(16'h0001, 16'h8000, 16, 16);
    noisy = 1;
    send_frame(16'h9876, 16'h5432, 16, 16);
    send_frame(16'hFFFF, 16'h0000, 17, 16);
    drain("R4 R9 tunnelled clock");

    // R10 overflow
    noisy = 0; clk_src = 1'b0;
    for (int i = 0; i < DEPTH + 1; i++)
      send_frame(16'(i * 16'h1111 + 3), 16'(~(i * 16'h0707)), 16, 16);
    chk("R10 level full", 32'(fifo_level), 32'(DEPTH));
    chk("R10 overrun set", 32'(overrun), 32'd1);
    drain("R10 kept entries");
    chk("R10 overrun sticky", 32'(overrun), 32'd1);

    // R11 pop on empty
    pop = 1'b1;
    step(mkw(1'b1, rb(), rb(), rb(), rb()));
    pop = 1'b0;
    chk("R11 pop empty level", 32'(fifo_level), 32'd0);
    chk("R11 pop empty flag", 32'(fifo_empty), 32'd1);

    // random batches
    for (int b = 0; b < 6; b++) begin
      clk_src = rb();
      noisy = 1;
      for (int f = 0; f < 1 + ($urandom % DEPTH); f++) begin
        int sl, sr;
        sl = ($urandom % 5 == 0) ? 10 + ($urandom % 9) : 16;
        sr = ($urandom % 5 == 0) ? 10 + ($urandom % 9) : 16;
        send_frame(16'($urandom), 16'($urandom), sl, sr);
      end
      drain("R6 R7 R8 R9 random batch");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule